// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical raster timing of a display controller. Two counters run in the pixel clock domain. The horizontal counter steps once per pixel. The vertical counter steps once per horizontal wrap. A bank of 32-bit timing words decides, from the counter values, when the display is active, when it is blanked and when the CRT and flat-panel sync pulses are high.

Each timing word carries two 16-bit fields, low half L and high half H. Both are written as "value minus one". Software fills the bank through a simple write port. The port accepts timing and configuration writes only while a key register holds a fixed unlock value. A read port returns any register at any time.

A typical setup sequence is: unlock, program the geometry, set the enables in the configuration word, then relock. The flat-panel vertical pair is normally written with start and end minus two, which makes it lead the CRT vertical sync by one line.

Top module: `disp_timing_gen`

## Requirements
- R1: While reset is asserted: both counters are 0, `blank` is 1, `de` and all four sync outputs are 0, the block is locked, and every register reads 0.
- R2: While locked, writes to addresses 1 to 9 leave the register contents unchanged, as observed on the read port.
- R3: Writing the value KEY (default 32'h0000_5A3C) to address 0 unlocks the block. Writing any other value to address 0, including zero, locks it. Address 0 reads back as 1 when unlocked and 0 when locked.
- R4: Reads are permitted whether the block is locked or not. Address 1 (configuration) keeps only bits 4:0. Addresses 2 to 9 return the full 32-bit word last written. Addresses 10 to 15 read as 0.
- R5: The horizontal counter counts 0 to HT and then returns to 0. HT is the high half of address 2.
- R6: The vertical counter advances only in the cycle the horizontal counter wraps, counts 0 to VT and then returns to 0. VT is the high half of address 5.
- R7: Configuration bit 0 enables the timing generator. While it is 0: both counters hold 0, `blank` is 1, and `de` and all syncs are 0. After the enabling write, the first cycle shows pixel 0, line 0.
- R8: `de` is 1 only when the generator is enabled, the horizontal count is ≤ the low half of address 2, and the vertical count is ≤ the low half of address 5.
- R9: With the generator enabled and configuration bit 1 set, `blank` is 1 when L < hcount ≤ H for address 3, or L < vcount ≤ H for address 6. With bit 1 clear, `blank` is 0.
- R10: `hsync` is 1 when configuration bit 2 is set and L < hcount ≤ H for address 4. `vsync` is 1 when bit 3 is set and L < vcount ≤ H for address 7. Both are active high and require the generator to be enabled.
- R11: Configuration bit 4 enables the flat-panel pair. `fp_hsync` follows address 8 and `fp_vsync` follows address 9, using the rule of R10. Written with start and end minus two, `fp_vsync` rises one line before `vsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| hcount | output | CW | Horizontal pixel counter |
| vcount | output | CW | Vertical line counter |
| hsync | output | 1 | CRT horizontal sync |
| vsync | output | 1 | CRT vertical sync |
| fp_hsync | output | 1 | Flat-panel horizontal sync |
| fp_vsync | output | 1 | Flat-panel vertical sync |
| blank | output | 1 | Display blank |
| de | output | 1 | Display enable (active area) |

## Verification
The bench targets the off-by-one edges of the window rule.
- A design that compares with ≥ instead of > on the low half starts sync and blank one pixel early.
- A design that compares with < on the high half ends them one pixel short.
- A design that wraps at total instead of at total-minus-one stretches every line by a pixel.

Lock handling is probed in two ways. A locked write that leaks into the bank changes a read-back value. A relock that triggers only on zero leaves the block open after a stray key value. Disabling the generator in mid-frame and re-enabling it exposes counters that resume instead of restarting at 0, 0. The one-line lead of the flat-panel vertical sync is measured directly against the CRT sync.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int NREG   = 10;
  localparam int A_KEY  = 0;
  localparam int A_CFG  = 1;
  localparam int A_HAT  = 2;
  localparam int A_HBL  = 3;
  localparam int A_HSY  = 4;
  localparam int A_VAT  = 5;
  localparam int A_VBL  = 6;
  localparam int A_VSY  = 7;
  localparam int A_FPH  = 8;
  localparam int A_FPV  = 9;
  localparam int CFG_W  = 5;
  localparam int B_TG   = 0;
  localparam int B_BLK  = 1;
  localparam int B_HS   = 2;
  localparam int B_VS   = 3;
  localparam int B_FP   = 4;
  localparam int NWIN   = 6;

  // window index -> register holding its (lo, hi) pair; even = horizontal
  function automatic int win_reg(input int i);
    case (i)
      0: return A_HBL;
      1: return A_VBL;
      2: return A_HSY;
      3: return A_VSY;
      4: return A_FPH;
      default: return A_FPV;
    endcase
  endfunction
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int          AW  = 4,
  parameter logic [31:0] KEY = 32'h0000_5A3C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [31:0]           rd_data,
  output logic [NREG-1:0][31:0] regs_o
);
  logic unl_q, unl_d;

  always_comb begin
    unl_d = unl_q;
    if (wr_en && wr_addr == AW'(A_KEY)) unl_d = (wr_data == KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unl_q <= 1'b0;
    else        unl_q <= unl_d;
  end

  assign regs_o[A_KEY] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    localparam logic [31:0] MASK = (i == A_CFG) ? 32'((1 << CFG_W) - 1) : 32'hFFFF_FFFF;
    logic        we;
    logic [31:0] q, d;
    assign we = wr_en && unl_q && (wr_addr == AW'(i));
    always_comb d = we ? (wr_data & MASK) : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign regs_o[i] = q;
  end

  always_comb begin
    if (rd_addr == AW'(A_KEY))             rd_data = {31'b0, unl_q};
    else if (32'(rd_addr) < NREG)          rd_data = regs_o[rd_addr];
    else                                   rd_data = '0;
  end

  // R2: a write while locked leaves the bank untouched
  a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unl_q && wr_addr != AW'(A_KEY)) |=> $stable(regs_o));
  // R3: any non-key value at the key address locks
  a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(A_KEY) && wr_data != KEY) |=> (rd_addr != AW'(A_KEY) || rd_data == 32'd0));
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          step,
  input  logic [CW-1:0] tot,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [CW-1:0] cnt_d;

  assign wrap = en && step && (cnt == tot);

  always_comb begin
    if (!en)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (step) cnt_d = cnt + 1'b1;
    else           cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R7: disabled generator parks the counter at 0
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);
  // R5/R6: return to 0 after the terminal count
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && cnt == tot) |=> cnt == '0);
  // R5/R6: single step below the terminal count
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && cnt < tot) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/dtg_window.sv
module dtg_window #(
  parameter int W = 12
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  assign hit = (cnt > lo) && (cnt <= hi);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int          CW  = 12,
  parameter int          AW  = 4,
  parameter logic [31:0] KEY = 32'h0000_5A3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic [CW-1:0] hcount,
  output logic [CW-1:0] vcount,
  output logic          hsync,
  output logic          vsync,
  output logic          fp_hsync,
  output logic          fp_vsync,
  output logic          blank,
  output logic          de
);
  logic [1:0]           rsync_q;
  logic                 rst_i;
  logic [NREG-1:0][31:0] regs;
  logic [CFG_W-1:0]     cfg;
  logic                 tg, hwrap, vwrap;
  logic [NWIN-1:0]      win;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  dtg_regs #(.AW(AW), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .regs_o(regs));

  assign cfg = regs[A_CFG][CFG_W-1:0];
  assign tg  = cfg[B_TG];

  dtg_axis #(.CW(CW)) u_h (
    .clk(clk), .rst_n(rst_i), .en(tg), .step(1'b1),
    .tot(regs[A_HAT][16 +: CW]), .cnt(hcount), .wrap(hwrap));

  dtg_axis #(.CW(CW)) u_v (
    .clk(clk), .rst_n(rst_i), .en(tg), .step(hwrap),
    .tot(regs[A_VAT][16 +: CW]), .cnt(vcount), .wrap(vwrap));

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam int RI = win_reg(i);
    logic [CW-1:0] c;
    assign c = (i % 2 == 0) ? hcount : vcount;
    dtg_window #(.W(CW)) u_w (
      .cnt(c), .lo(regs[RI][0 +: CW]), .hi(regs[RI][16 +: CW]), .hit(win[i]));
  end

  always_comb begin
    de       = tg && (hcount <= regs[A_HAT][0 +: CW]) && (vcount <= regs[A_VAT][0 +: CW]);
    blank    = !tg || (cfg[B_BLK] && (win[0] || win[1]));
    hsync    = tg && cfg[B_HS] && win[2];
    vsync    = tg && cfg[B_VS] && win[3];
    fp_hsync = tg && cfg[B_FP] && win[4];
    fp_vsync = tg && cfg[B_FP] && win[5];
  end

  // R6: the line counter moves only on a pixel wrap
  a_r6_vhold: assert property (@(posedge clk) disable iff (!rst_i)
    (tg && !hwrap) |=> $stable(vcount));
  // R6: a frame wrap coincides with a line wrap
  a_r6_frame: assert property (@(posedge clk) disable iff (!rst_i)
    vwrap |-> hwrap);
endmodule

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
module sim_disp_timing_gen;
  localparam int CW = 12;
  localparam int MSK = (1 << CW) - 1;
  localparam logic [31:0] KEY = 32'h0000_5A3C;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [CW-1:0] hcount, vcount;
  logic hsync, vsync, fp_hsync, fp_vsync, blank, de;

  int total = 0, bad = 0;
  bit model_on = 0;
  int m_hc = 0, m_vc = 0, m_unl = 0;
  int m_r [10];
  int vs_line = -1, fpv_line = -1;
  bit prev_vs = 0, prev_fpv = 0;

  always #10 clk = ~clk;

  disp_timing_gen #(.CW(CW), .AW(4), .KEY(KEY)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hcount(hcount), .vcount(vcount),
    .hsync(hsync), .vsync(vsync), .fp_hsync(fp_hsync), .fp_vsync(fp_vsync),
    .blank(blank), .de(de));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lo(input int a); return m_r[a] & MSK; endfunction
  function automatic int hi(input int a); return (m_r[a] >>> 16) & MSK; endfunction
  function automatic bit inwin(input int c, input int a); return c > lo(a) && c <= hi(a); endfunction

  // reference model: advance on the clock edge
  always @(posedge clk) if (model_on) begin
    if (!m_r[1][0]) begin m_hc = 0; m_vc = 0; end
    else if (m_hc == hi(2)) begin
      m_hc = 0;
      m_vc = (m_vc == hi(5)) ? 0 : ((m_vc + 1) & MSK);
    end else m_hc = (m_hc + 1) & MSK;
    if (wr_en) begin
      if (wr_addr == 0) m_unl = (wr_data == KEY);
      else if (m_unl && wr_addr <= 9) m_r[wr_addr] = (wr_addr == 1) ? (wr_data & 32'h1F) : wr_data;
    end
  end

  // compare mid-cycle
  always @(negedge clk) if (model_on) begin
    bit tg; int exp_rd;
    tg = m_r[1][0];
    chk(hcount == m_hc, "R5 hcount", hcount, m_hc);
    chk(vcount == m_vc, "R6 vcount", vcount, m_vc);
    chk(de == (tg && m_hc <= lo(2) && m_vc <= lo(5)), "R8 de", de, !de);
    chk(blank == (!tg || (m_r[1][1] && (inwin(m_hc,3) || inwin(m_vc,6)))), "R9 blank", blank, !blank);
    chk(hsync == (tg && m_r[1][2] && inwin(m_hc,4)), "R10 hsync", hsync, !hsync);
    chk(vsync == (tg && m_r[1][3] && inwin(m_vc,7)), "R10 vsync", vsync, !vsync);
    chk(fp_hsync == (tg && m_r[1][4] && inwin(m_hc,8)), "R11 fp_hsync", fp_hsync, !fp_hsync);
    chk(fp_vsync == (tg && m_r[1][4] && inwin(m_vc,9)), "R11 fp_vsync", fp_vsync, !fp_vsync);
    exp_rd = (rd_addr == 0) ? m_unl : (rd_addr <= 9 ? m_r[rd_addr] : 0);
    chk(rd_data == 32'(exp_rd), "R4 rd_data", rd_data, 32'(exp_rd));
    if (vsync && !prev_vs && vs_line < 0) vs_line = vcount;
    if (fp_vsync && !prev_fpv && fpv_line < 0) fpv_line = vcount;
    prev_vs = vsync; prev_fpv = fp_vsync;
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #2; wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(posedge clk); #2; wr_en = 0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    @(posedge clk); #2; rd_addr = 4'(a);
    @(negedge clk); chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic geometry(input int ha, input int hf, input int hs, input int hb,
                          input int va, input int vf, input int vs, input int vb);
    int ht, vt;
    ht = ha + hf + hs + hb; vt = va + vf + vs + vb;
    wr(2, {16'(ht-1), 16'(ha-1)});
    wr(3, {16'(ht-1), 16'(ha-1)});
    wr(4, {16'(ha+hf+hs-1), 16'(ha+hf-1)});
    wr(8, {16'(ha+hf+hs-1), 16'(ha+hf-1)});
    wr(5, {16'(vt-1), 16'(va-1)});
    wr(6, {16'(vt-1), 16'(va-1)});
    wr(7, {16'(va+vf+vs-1), 16'(va+vf-1)});
    wr(9, {16'(va+vf+vs-2), 16'(va+vf-2)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (m_r[i]) m_r[i] = 0;
    idle(3);
    #5;
    // R1: reset state
    chk(hcount == 0 && vcount == 0, "R1 counters", {hcount, vcount}, 0);
    chk(blank == 1 && de == 0, "R1 blank/de", {blank, de}, 2'b10);
    chk({hsync, vsync, fp_hsync, fp_vsync} == 0, "R1 syncs", {hsync, vsync, fp_hsync, fp_vsync}, 0);
    for (int a = 0; a < 10; a++) begin
      rd_addr = 4'(a); #1;
      chk(rd_data == 0, "R1 register", rd_data, 0);
    end
    @(posedge clk); #2; rst_n = 1;
    idle(4);
    model_on = 1;
    // R2: locked write is dropped
    wr(2, 32'h0011_0022);
    rd_chk(2, 32'h0, "R2 locked write");
    rd_chk(0, 32'h0, "R3 locked flag");
    // R3: unlock
    wr(0, KEY);
    rd_chk(0, 32'h1, "R3 unlocked flag");
    geometry(8, 2, 3, 3, 4, 1, 2, 1);
    rd_chk(9, {16'd5, 16'd3}, "R4 fp vsync word");
    // R7: enable; first cycle shows pixel 0
    @(posedge clk); #2; wr_en = 1; wr_addr = 1; wr_data = 32'hFFFF_FFFF;
    @(posedge clk); #2; wr_en = 0;
    @(negedge clk); chk(hcount == 0 && vcount == 0, "R7 restart at 0", hcount, 0);
    @(negedge clk); chk(hcount == 1, "R7 first step", hcount, 1);
    rd_chk(1, 32'h1F, "R4 cfg mask");
    idle(300);
    chk(vs_line == 5, "R10 vsync line", vs_line, 5);
    chk(fpv_line == vs_line - 1, "R11 fp lead", fpv_line, vs_line - 1);
    // R9: blank enable off
    wr(1, 32'h1D); idle(140);
    // R10: hsync off, vsync off
    wr(1, 32'h19); idle(70);
    wr(1, 32'h13); idle(140);
    // R11: flat panel off
    wr(1, 32'h0F); idle(70);
    // R7: stop mid-frame then restart
    wr(1, 32'h00); idle(20);
    chk(hcount == 0 && blank == 1 && de == 0, "R7 stopped", hcount, 0);
    wr(1, 32'h1F); idle(50);
    // R3: stray value relocks
    wr(0, 32'h0000_1234);
    rd_chk(0, 32'h0, "R3 stray relock");
    wr(1, 32'h0); wr(2, 32'hDEAD_BEEF);
    rd_chk(1, 32'h1F, "R2 cfg kept");
    rd_chk(2, {16'd15, 16'd7}, "R2 timing kept");
    rd_chk(12, 32'h0, "R4 unmapped");
    idle(80);
    // new geometry while stopped
    wr(0, KEY); wr(1, 32'h0);
    geometry(10, 3, 4, 2, 5, 2, 3, 2);
    wr(1, 32'h1F); idle(19 * 12 * 2 + 10);
    // R3: zero relocks
    wr(0, 32'h0);
    rd_chk(0, 32'h0, "R3 zero relock");
    idle(20);
    model_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule